// File: doc/BRIEF.md
# Receive Descriptor-Ring DMA Writer

This block takes incoming frames from a 32-bit word stream and stores them in memory buffers. Software describes those buffers with a ring of descriptors in memory. Each descriptor is two 32-bit words: the word at the descriptor address holds the buffer's byte address, and the word at address + 4 holds control and status. The block keeps two registers that software can write: a ring base and a current-descriptor pointer. When a frame starts and reception is enabled, the block reads the descriptor that the pointer selects. It checks that hardware still owns the descriptor, then writes the frame words into that descriptor's buffer.

When a buffer fills or the frame ends, the block writes the status word back. That write sets the ownership bit, which hands the buffer to software, and records the start-of-frame and end-of-frame marks and the number of bytes stored. The pointer then moves to the next descriptor, or returns to the base when the descriptor carries the wrap bit. A frame longer than one buffer continues into the following descriptors. The interrupt status has two sticky bits, one for a completed frame and one for an overrun. The single interrupt output is their OR, masked by an enable input.

The frame stream uses valid/ready handshaking. A beat transfers in a cycle where `s_valid` and `s_ready` are both high. The source must hold `s_valid` and its data stable until that happens. The block lowers `s_ready` whenever a buffer write cannot complete in the current cycle: while it fetches or writes back a descriptor, and while the memory port withholds `mem_ack`. A frame that is being dropped is accepted at full rate. On the memory port, a request stays asserted with a stable address until `mem_ack` arrives. Read data is sampled in the cycle of `mem_ack`.

Top module: `rx_ring_dma`

## Requirements
- R1: After reset, `s_ready`, `mem_req`, `irq` and `irq_status` are 0, and the pointer and base read 0.
- R2: A descriptor is fetched as two reads: the buffer address from the pointer address, then the control word from pointer + 4. In the control word, bits 12:0 are the buffer length in bytes, bit 14 marks start of frame, bit 15 marks end of frame, bit 30 is wrap and bit 31 is ownership.
- R3: Frame beats are written to consecutive word addresses starting at the buffer address. A beat transfers only in a cycle whose buffer write is acknowledged, so stalls on the memory port create back-pressure without losing data.
- R4: The write-back goes to pointer + 4. It sets bit 31, keeps the fetched wrap bit, and puts the number of bytes stored in bits 12:0. On the last beat, `s_lastbytes` gives the valid bytes (1 to 3), and 0 means all 4.
- R5: After a write-back, the pointer advances by 8 if the descriptor's wrap bit is 0.
- R6: After a write-back, the pointer reloads from the base register if the descriptor's wrap bit is 1. End of frame never causes this reload.
- R7: A frame that overflows a buffer continues into the next descriptors. Only the first descriptor of the frame gets the start-of-frame bit, and only the last gets the end-of-frame bit.
- R8: Writing back the end-of-frame descriptor sets status bit 0 (frame received).
- R9: If a fetched descriptor already has ownership bit 31 set, the remaining beats of the frame are consumed but not written, status bit 1 (overrun) is set, and the pointer does not move.
- R10: While `rx_en` is 0 at a frame boundary, no beat is accepted and no memory request is made. Clearing `rx_en` partway through a frame still lets that frame finish.
- R11: Status bits stay set until a 1 is written to them on `irq_clr`. `irq` is the OR of the status bits that `irq_en` enables.
- R12: Software writes to the base (`base_we`) and the pointer (`qptr_we`) take effect on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_en | input | 1 | Receive enable, sampled at frame boundaries |
| base_we | input | 1 | Write strobe for the ring base |
| base_wdata | input | AW | New ring base |
| qptr_we | input | 1 | Write strobe for the descriptor pointer |
| qptr_wdata | input | AW | New descriptor pointer |
| qptr_o | output | AW | Current descriptor pointer |
| irq_en | input | 2 | Interrupt enables (bit 0 frame, bit 1 overrun) |
| irq_clr | input | 2 | Write-1-to-clear pulses for the status bits |
| irq_status | output | 2 | Sticky status (bit 0 frame, bit 1 overrun) |
| irq | output | 1 | Combined interrupt |
| s_valid | input | 1 | Stream beat valid |
| s_ready | output | 1 | Stream beat accepted |
| s_data | input | 32 | Stream data word |
| s_last | input | 1 | Last beat of frame |
| s_lastbytes | input | 2 | Valid bytes in the last beat, 0 meaning 4 |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | AW | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid with `mem_ack` |
| mem_ack | input | 1 | Memory request completed |

## Verification
The bench sends a frame that spills across two buffers and ends on a descriptor with the wrap bit set. A design that marked every piece as start of frame, or wrapped on end of frame, would write back the wrong status words or leave the pointer in the wrong place. Another test reaches a descriptor that software still owns. A design that wrote the frame anyway, moved the pointer, or stalled the stream would leave the old buffer data overwritten, the pointer shifted, or the bench stuck. Further tests clear the enable in the middle of a frame, stall every other memory acknowledge, and give a short last beat. These catch a block that cuts frames short, loses beats under back-pressure, or stores a wrong byte count.

// File: rtl/rx_dma_pkg.sv
package rx_dma_pkg;
  localparam int WORD_W     = 32;
  localparam int LEN_W      = 13;
  localparam int SOF_BIT    = 14;
  localparam int EOF_BIT    = 15;
  localparam int WRAP_BIT   = 30;
  localparam int OWN_BIT    = 31;
  localparam int DESC_BYTES = 8;
  localparam int ST_DONE    = 0;
  localparam int ST_OVR     = 1;
  localparam int NUM_IRQ    = 2;

  typedef enum logic [2:0] {
    S_IDLE,
    S_RD_ADDR,
    S_RD_CTRL,
    S_FILL,
    S_WB,
    S_DROP
  } rx_state_e;
endpackage

// File: rtl/rx_dma_ptr.sv
module rx_dma_ptr #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          base_we,
  input  logic [AW-1:0] base_wdata,
  input  logic          qptr_we,
  input  logic [AW-1:0] qptr_wdata,
  input  logic          adv,
  input  logic          adv_wrap,
  output logic [AW-1:0] qptr
);
  import rx_dma_pkg::*;
  localparam logic [AW-1:0] STEP = AW'(DESC_BYTES);

  logic [AW-1:0] base_q, qptr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      qptr_q <= '0;
    end else begin
      if (base_we) base_q <= base_wdata;
      if (qptr_we) qptr_q <= qptr_wdata;
      else if (adv) qptr_q <= adv_wrap ? base_q : qptr_q + STEP;
    end
  end

  assign qptr = qptr_q;

  // R5 R6
  qptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !qptr_we && !base_we) |=>
      (qptr_q == $past(base_q) || qptr_q == $past(qptr_q) + STEP));

  // R6
  qptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !qptr_we) |=> $stable(qptr_q));
endmodule

// File: rtl/rx_dma_irq.sv
module rx_dma_irq (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] set_i,
  input  logic [1:0] clr_i,
  input  logic [1:0] en_i,
  output logic [1:0] status_o,
  output logic       irq_o
);
  import rx_dma_pkg::*;

  logic [NUM_IRQ-1:0] st_q;

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n) st_q[i] <= 1'b0;
      else if (set_i[i]) st_q[i] <= 1'b1;
      else if (clr_i[i]) st_q[i] <= 1'b0;
    end

    // R11
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q[i] && !clr_i[i]) |=> st_q[i]);

    // R11
    w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i[i] && !set_i[i]) |=> !st_q[i]);
  end

  assign status_o = st_q;
  assign irq_o    = |(st_q & en_i);
endmodule

// File: rtl/rx_dma_engine.sv
module rx_dma_engine #(
  parameter int AW = 32
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           rx_en,
  input  logic [AW-1:0]                  qptr,
  input  logic                           s_valid,
  output logic                           s_ready,
  input  logic [rx_dma_pkg::WORD_W-1:0]  s_data,
  input  logic                           s_last,
  input  logic [1:0]                     s_lastbytes,
  output logic                           mem_req,
  output logic                           mem_we,
  output logic [AW-1:0]                  mem_addr,
  output logic [rx_dma_pkg::WORD_W-1:0]  mem_wdata,
  input  logic [rx_dma_pkg::WORD_W-1:0]  mem_rdata,
  input  logic                           mem_ack,
  output logic                           adv,
  output logic                           adv_wrap,
  output logic                           frame_done,
  output logic                           overrun
);
  import rx_dma_pkg::*;
  localparam int CNT_W = LEN_W + 1;
  localparam logic [AW-1:0] CTRL_OFS = AW'(4);

  rx_state_e         state_q, state_d;
  logic [AW-1:0]     buf_q;
  logic [LEN_W-1:0]  len_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              wrap_q, sof_q, eof_q;
  logic              room, beat, own_hit;
  logic [CNT_W-1:0]  inc;
  logic [WORD_W-1:0] wb_word;

  assign room    = cnt_q < {1'b0, len_q};
  assign inc     = (s_last && s_lastbytes != 2'd0) ? CNT_W'(s_lastbytes) : CNT_W'(4);
  assign own_hit = mem_rdata[OWN_BIT];
  assign beat    = s_valid && s_ready;

  always_comb begin
    wb_word           = '0;
    wb_word[LEN_W-1:0] = cnt_q[LEN_W-1:0];
    wb_word[SOF_BIT]  = sof_q;
    wb_word[EOF_BIT]  = eof_q;
    wb_word[WRAP_BIT] = wrap_q;
    wb_word[OWN_BIT]  = 1'b1;
  end

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = qptr;
    mem_wdata = '0;
    s_ready   = 1'b0;
    unique case (state_q)
      S_RD_ADDR: mem_req = 1'b1;
      S_RD_CTRL: begin
        mem_req  = 1'b1;
        mem_addr = qptr + CTRL_OFS;
      end
      S_FILL: if (room) begin
        mem_req   = s_valid;
        mem_we    = 1'b1;
        mem_addr  = buf_q + AW'(cnt_q);
        mem_wdata = s_data;
        s_ready   = mem_ack;
      end
      S_WB: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = qptr + CTRL_OFS;
        mem_wdata = wb_word;
      end
      S_DROP: s_ready = 1'b1;
      default: ;
    endcase
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE:    if (rx_en && s_valid) state_d = S_RD_ADDR;
      S_RD_ADDR: if (mem_ack) state_d = S_RD_CTRL;
      S_RD_CTRL: if (mem_ack) state_d = own_hit ? S_DROP : S_FILL;
      S_FILL:    if (!room || (beat && s_last)) state_d = S_WB;
      S_WB:      if (mem_ack) state_d = eof_q ? S_IDLE : S_RD_ADDR;
      S_DROP:    if (beat && s_last) state_d = S_IDLE;
      default:   state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      buf_q   <= '0;
      len_q   <= '0;
      cnt_q   <= '0;
      wrap_q  <= 1'b0;
      sof_q   <= 1'b1;
      eof_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      unique case (state_q)
        S_RD_ADDR: if (mem_ack) buf_q <= mem_rdata[AW-1:0];
        S_RD_CTRL: if (mem_ack) begin
          len_q  <= mem_rdata[LEN_W-1:0];
          wrap_q <= mem_rdata[WRAP_BIT];
          cnt_q  <= '0;
          eof_q  <= 1'b0;
        end
        S_FILL: if (beat) begin
          cnt_q <= cnt_q + inc;
          eof_q <= s_last;
        end
        S_WB:   if (mem_ack) sof_q <= eof_q;
        S_DROP: if (beat && s_last) sof_q <= 1'b1;
        default: ;
      endcase
    end
  end

  assign adv        = (state_q == S_WB) && mem_ack;
  assign adv_wrap   = wrap_q;
  assign frame_done = adv && eof_q;
  assign overrun    = (state_q == S_RD_CTRL) && mem_ack && own_hit;

  // R3
  ready_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> (state_q == S_FILL || state_q == S_DROP));

  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && state_q == S_FILL) |-> room);

  // R2
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

  // R4
  own_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_WB && mem_req) |-> (mem_we && mem_wdata[OWN_BIT]));

  // R9
  drop_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_DROP) |-> !mem_req);

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_IDLE) |-> (!mem_req && !s_ready));
endmodule

// File: rtl/rx_ring_dma.sv
module rx_ring_dma #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_en,
  input  logic          base_we,
  input  logic [AW-1:0] base_wdata,
  input  logic          qptr_we,
  input  logic [AW-1:0] qptr_wdata,
  output logic [AW-1:0] qptr_o,
  input  logic [1:0]    irq_en,
  input  logic [1:0]    irq_clr,
  output logic [1:0]    irq_status,
  output logic          irq,
  input  logic          s_valid,
  output logic          s_ready,
  input  logic [31:0]   s_data,
  input  logic          s_last,
  input  logic [1:0]    s_lastbytes,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic [31:0]   mem_rdata,
  input  logic          mem_ack
);
  logic adv, adv_wrap, frame_done, overrun;

  rx_dma_ptr #(.AW(AW)) u_ptr (
    .clk(clk), .rst_n(rst_n),
    .base_we(base_we), .base_wdata(base_wdata),
    .qptr_we(qptr_we), .qptr_wdata(qptr_wdata),
    .adv(adv), .adv_wrap(adv_wrap), .qptr(qptr_o)
  );

  rx_dma_engine #(.AW(AW)) u_eng (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .qptr(qptr_o),
    .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .s_last(s_last), .s_lastbytes(s_lastbytes),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
    .adv(adv), .adv_wrap(adv_wrap),
    .frame_done(frame_done), .overrun(overrun)
  );

  rx_dma_irq u_irq (
    .clk(clk), .rst_n(rst_n),
    .set_i({overrun, frame_done}), .clr_i(irq_clr), .en_i(irq_en),
    .status_o(irq_status), .irq_o(irq)
  );
endmodule

// File: tb/tb_rx_ring_dma.sv
module tb_rx_ring_dma;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_en = 1'b0;
  logic        base_we = 1'b0, qptr_we = 1'b0;
  logic [31:0] base_wdata = '0, qptr_wdata = '0, qptr_o;
  logic [1:0]  irq_en = '0, irq_clr = '0, irq_status;
  logic        irq;
  logic        s_valid = 1'b0, s_ready, s_last = 1'b0;
  logic [31:0] s_data = '0;
  logic [1:0]  s_lastbytes = '0;
  logic        mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        ack_toggle = 1'b0, ack_phase = 1'b0;
  logic [31:0] mem [0:1023];
  int          checks = 0, failures = 0, cyc = 0;
  bit          finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_ring_dma dut (.*);

  assign mem_ack   = ack_toggle ? ack_phase : 1'b1;
  assign mem_rdata = mem[mem_addr[11:2]];

  always @(posedge clk) if (mem_req && mem_we && mem_ack) mem[mem_addr[11:2]] <= mem_wdata;
  always @(negedge clk) ack_phase <= ~ack_phase;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input int n, input logic [1:0] lb, input logic [31:0] seed);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      s_valid = 1'b1; s_data = seed + i; s_last = (i == n-1); s_lastbytes = lb;
      #1;
      while (!s_ready) begin @(negedge clk); #1; end
      @(posedge clk);
    end
    @(negedge clk);
    s_valid = 1'b0; s_last = 1'b0;
  endtask

  task automatic set_desc(input int a, input logic [31:0] buf_addr, input logic [31:0] ctrl);
    mem[a/4] = buf_addr;
    mem[a/4 + 1] = ctrl;
  endtask

  task automatic clear_irq(input logic [1:0] bits);
    @(negedge clk); irq_clr = bits;
    @(negedge clk); irq_clr = 2'b00;
  endtask

  task automatic t_reset;
    #1;
    chk("R1 s_ready", {31'b0, s_ready}, 32'd0);
    chk("R1 mem_req", {31'b0, mem_req}, 32'd0);
    chk("R1 status/irq", {29'b0, irq_status, irq}, 32'd0);
    chk("R1 qptr", qptr_o, 32'd0);
  endtask

  task automatic t_single;
    @(negedge clk);
    base_we = 1'b1; base_wdata = 32'h100; qptr_we = 1'b1; qptr_wdata = 32'h100;
    @(negedge clk);
    base_we = 1'b0; qptr_we = 1'b0;
    chk("R12 qptr written", qptr_o, 32'h100);
    set_desc(32'h100, 32'h400, 32'd64);
    rx_en = 1'b1; irq_en = 2'b01;
    send(3, 2'd2, 32'hA000_0000);
    idle(6);
    chk("R3 word0", mem[32'h400/4], 32'hA000_0000);
    chk("R3 word2", mem[32'h408/4], 32'hA000_0002);
    chk("R4 writeback sof|eof|10", mem[32'h104/4], 32'h8000_C00A);
    chk("R5 advance by 8", qptr_o, 32'h108);
    chk("R8 done status", {30'b0, irq_status}, 32'd1);
    chk("R11 irq enabled", {31'b0, irq}, 32'd1);
    clear_irq(2'b01);
    chk("R11 w1c clears", {29'b0, irq_status, irq}, 32'd0);
  endtask

  task automatic t_spill;
    set_desc(32'h108, 32'h500, 32'd8);
    set_desc(32'h110, 32'h600, 32'h4000_0040);
    send(5, 2'd0, 32'hB000_0000);
    idle(8);
    chk("R7 first piece sof only", mem[32'h10C/4], 32'h8000_4008);
    chk("R7 last piece eof wrap", mem[32'h114/4], 32'hC000_800C);
    chk("R7 spill data", mem[32'h600/4], 32'hB000_0002);
    chk("R6 wrap to base", qptr_o, 32'h100);
    chk("R8 done after spill", {30'b0, irq_status}, 32'd1);
    clear_irq(2'b01);
  endtask

  task automatic t_owned;
    irq_en = 2'b10;
    send(2, 2'd0, 32'hC000_0000);
    idle(5);
    chk("R9 overrun flag", {30'b0, irq_status}, 32'd2);
    chk("R9 pointer held", qptr_o, 32'h100);
    chk("R9 buffer untouched", mem[32'h400/4], 32'hA000_0000);
    chk("R11 irq on overrun", {31'b0, irq}, 32'd1);
    @(negedge clk); irq_en = 2'b01; #1;
    chk("R11 masked irq", {31'b0, irq}, 32'd0);
    clear_irq(2'b10);
  endtask

  task automatic t_qptr_write;
    set_desc(32'h118, 32'h700, 32'h4000_0040);
    @(negedge clk); qptr_we = 1'b1; qptr_wdata = 32'h118;
    @(negedge clk); qptr_we = 1'b0;
    send(1, 2'd1, 32'hD000_0000);
    idle(6);
    chk("R12 frame at written qptr", mem[32'h700/4], 32'hD000_0000);
    chk("R4 one byte stored", mem[32'h11C/4], 32'hC000_C001);
    chk("R6 wrap after written qptr", qptr_o, 32'h100);
    clear_irq(2'b01);
  endtask

  task automatic t_enable;
    int rdy = 0, req = 0;
    set_desc(32'h100, 32'h400, 32'd64);
    @(negedge clk); rx_en = 1'b0;
    s_valid = 1'b1; s_data = 32'hE; s_last = 1'b1; s_lastbytes = 2'd0;
    repeat (10) begin @(negedge clk); #1; rdy += s_ready; req += mem_req; end
    s_valid = 1'b0; s_last = 1'b0;
    chk("R10 no accept while disabled", rdy, 0);
    chk("R10 no memory while disabled", req, 0);
    @(negedge clk); rx_en = 1'b1;
    fork
      send(3, 2'd0, 32'hF000_0000);
      begin
        @(posedge clk iff (s_valid && s_ready));
        @(negedge clk); rx_en = 1'b0;
      end
    join
    idle(6);
    chk("R10 frame finished after clear", mem[32'h104/4], 32'h8000_C00C);
    chk("R10 last data stored", mem[32'h408/4], 32'hF000_0002);
    chk("R5 advance after frame", qptr_o, 32'h108);
    clear_irq(2'b01);
  endtask

  task automatic t_stall;
    set_desc(32'h108, 32'h800, 32'd64);
    @(negedge clk); rx_en = 1'b1; ack_toggle = 1'b1;
    send(4, 2'd3, 32'h1234_0000);
    idle(10);
    ack_toggle = 1'b0;
    chk("R3 stalled word1", mem[32'h804/4], 32'h1234_0001);
    chk("R3 stalled word3", mem[32'h80C/4], 32'h1234_0003);
    chk("R4 stalled count 15", mem[32'h10C/4], 32'h8000_C00F);
    chk("R5 stalled advance", qptr_o, 32'h110);
    chk("R8 stalled done", {30'b0, irq_status}, 32'd1);
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 32'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_single();
    t_spill();
    t_owned();
    t_qptr_write();
    t_enable();
    t_stall();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule